// File: doc/BRIEF.md
# Multi-Group Conversion Sequencer

This block is the digital scheduler in front of a 12-input, 10-bit sample-and-hold converter. Three conversion groups share the converter. Each group has its own enable bit, its own mode bit and its own 12-bit channel mask. A group starts from a one-cycle software strobe. Groups 0 and 1 can also start from an asynchronous external trigger line. Group 2 is started only by software.

When a group is started, it walks its selected channels from the lowest number upward. For each channel it issues a start strobe and a channel index to the converter, then waits for the converter's done strobe. It then writes a tagged result word into that group's own result FIFO. Groups that are pending at the same time share the converter by fixed priority. The sequencer arbitrates again after every single conversion, so a higher-priority request can cut in between two channels of a lower-priority group. It never interrupts a conversion that is already running.

A group in one-shot mode makes one pass per trigger. A group in continuous mode starts the next pass as soon as the current pass ends. A one-cycle done strobe marks the end of every pass. Two kinds of event also give one-cycle strobes, each for the group concerned: a trigger that arrives while its group is busy, and a result that finds its FIFO full.

Top module: `adcseq_top`

## Requirements
- R1: `conv_start` is a one-cycle strobe, and `conv_ch` is always in the range 0 to 11 while it is high. No new start is issued until `conv_done` has returned for the conversion in flight.
- R2: Within a pass, the selected channels are converted in ascending channel order, and unselected channels take no conversion slot. Each result word has the channel index in bits 13:10, the 10-bit value in bits 9:0, and zeros in bits 15:14.
- R3: Each group has a 16-entry FIFO. `rd_word` shows the oldest entry, and `rd_pop` removes it. A result that reaches a full FIFO is discarded, the FIFO keeps its 16 older words, and `buf_overflow` pulses for that group.
- R4: Pending groups are served in fixed priority, with group 0 before group 1 before group 2. The choice is made again between every two conversions, so a higher-priority group takes the converter after the current conversion ends.
- R5: `ext_trig[0]` starts group 0 and `ext_trig[1]` starts group 1. Each line passes through a two-flop synchroniser and acts only on a rising edge. A line held high starts only one pass, and a falling edge starts nothing.
- R6: `sw_start[g]` starts group g only when `grp_en[g]` is high and the group's mask is nonzero. Otherwise the strobe has no effect. The mask is captured when the start is accepted, and later changes to it apply only to the next start.
- R7: A start request, from software or from an external line, that reaches a group which is already pending or converting is ignored, and `trig_overrun` pulses for that group.
- R8: When `grp_cont[g]` is low, the group makes one pass and then goes idle. When it is high, the group restarts from its lowest selected channel right after the last one.
- R9: `grp_done[g]` is high for exactly one cycle, in the cycle after the converter's done strobe for the last channel of a pass.
- R10: Dropping `grp_en[g]` lets a conversion that is in flight for that group complete and be stored, then stops the group with no done strobe. A pending start that has not yet been granted is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_en | input | 3 | Per-group enable |
| grp_cont | input | 3 | Per-group mode: 1 is continuous, 0 is one-shot |
| grp_mask | input | 36 | Channel masks, group g in bits 12g+11 down to 12g |
| sw_start | input | 3 | One-cycle software start, one bit per group |
| ext_trig | input | 2 | Asynchronous trigger lines for groups 0 and 1 |
| conv_start | output | 1 | Start strobe to the converter |
| conv_ch | output | 4 | Channel index for the conversion |
| conv_done | input | 1 | Converter finished; `conv_data` is valid |
| conv_data | input | 10 | Conversion value |
| rd_pop | input | 3 | Per-group FIFO pop |
| rd_word | output | 48 | Oldest FIFO word, group g in bits 16g+15 down to 16g |
| rd_empty | output | 3 | Per-group FIFO empty |
| grp_done | output | 3 | End-of-pass strobe |
| trig_overrun | output | 3 | Start request reached a busy group |
| buf_overflow | output | 3 | Result dropped because the FIFO was full |

## Verification
The bench sweeps one group through every third channel mask from 1 to 4095 and checks that each result word is in ascending channel order with the correct tag. A scan that stopped early, repeated a channel or gave a skipped channel a slot would show up as a wrong word count or a wrong tag. A start made in the middle of another group's pass must cut in between two channels. A design that kept the converter for the whole pass, or that pre-empted a conversion in flight, would log a different channel order. Further tests cover a held external line, which must give exactly one pass; a repeat start to a busy group; a group disabled while it is pending; and a continuous group overfilling its FIFO, where the first 16 words must survive and the overflow count must equal the number of dropped conversions.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    // Sequencer phase: waiting to grant, or a conversion is in flight.
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/adcseq_trig_sync.sv
module adcseq_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // Edge detect on the last synchronised stage against one stage later.
    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    // A rising edge is a single-cycle event (R5).
    assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/adcseq_fifo.sv
module adcseq_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         drop
);

    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t     s_q, s_d;
    logic [W-1:0] mem_q [DEPTH];
    logic         full, push, pop;

    assign full  = (s_q.cnt == (AW+1)'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign push  = wr & ~full;
    assign pop   = rd & ~empty;
    assign drop  = wr & full;
    assign rdata = mem_q[s_q.rp];

    always_comb begin
        s_d = s_q;
        if (push) s_d.wp = s_q.wp + 1'b1;
        if (pop)  s_d.rp = s_q.rp + 1'b1;
        case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[s_q.wp] <= wdata;
    end

    // A write into a full buffer must not change its occupancy (R3).
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd) |=> (s_q.cnt == (AW+1)'(DEPTH)));

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= (AW+1)'(DEPTH));

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
    parameter int NCH   = 12,
    parameter int DW    = 10,
    parameter int NGRP  = 3,
    parameter int NEXT  = 2,
    parameter int DEPTH = 16,
    parameter int WORDW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NGRP-1:0]       grp_en,
    input  logic [NGRP-1:0]       grp_cont,
    input  logic [NGRP*NCH-1:0]   grp_mask,
    input  logic [NGRP-1:0]       sw_start,
    input  logic [NEXT-1:0]       ext_trig,
    output logic                  conv_start,
    output logic [$clog2(NCH)-1:0] conv_ch,
    input  logic                  conv_done,
    input  logic [DW-1:0]         conv_data,
    input  logic [NGRP-1:0]       rd_pop,
    output logic [NGRP*WORDW-1:0] rd_word,
    output logic [NGRP-1:0]       rd_empty,
    output logic [NGRP-1:0]       grp_done,
    output logic [NGRP-1:0]       trig_overrun,
    output logic [NGRP-1:0]       buf_overflow
);

    import adcseq_pkg::*;

    localparam int CHW  = $clog2(NCH);
    localparam int GW   = $clog2(NGRP);
    localparam int PADW = WORDW - CHW - DW;

    typedef struct packed {
        seq_state_e                st;
        logic [GW-1:0]             cur;
        logic [NGRP-1:0]           pend;
        logic [NGRP-1:0][CHW-1:0]  pos;
        logic [NGRP-1:0][NCH-1:0]  smask;
        logic                      start;
        logic [CHW-1:0]            ch;
        logic [NGRP-1:0]           done;
        logic [NGRP-1:0]           ovr;
        logic [NGRP-1:0]           ovf;
    } seq_t;

    seq_t             q, d;
    logic [NGRP-1:0]  trig_req;
    logic [NEXT-1:0]  ext_rise;
    logic [NGRP-1:0]  fifo_wr;
    logic [NGRP-1:0]  fifo_drop;
    logic [WORDW-1:0] wword;
    logic [CHW:0]     nx;
    logic             pick;

    // Lowest selected channel at or above 'from'; MSB flags a hit.
    function automatic logic [CHW:0] scan_up(input logic [NCH-1:0] m, input int from);
        scan_up = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i] && i >= from) scan_up = {1'b1, CHW'(i)};
        end
    endfunction

    function automatic logic [CHW-1:0] first_idx(input logic [NCH-1:0] m);
        first_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i]) first_idx = CHW'(i);
        end
    endfunction

    // Trigger sources: external lines for the first NEXT groups only.
    for (genvar e = 0; e < NEXT; e++) begin : g_sync
        adcseq_trig_sync #(.STAGES(2)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (ext_trig[e]),
            .rise     (ext_rise[e])
        );
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_req
        if (g < NEXT) begin : g_ext
            assign trig_req[g] = sw_start[g] | ext_rise[g];
        end else begin : g_sw
            assign trig_req[g] = sw_start[g];
        end
    end

    assign wword = {{PADW{1'b0}}, q.ch, conv_data};

    always_comb begin
        d         = q;
        d.start   = 1'b0;
        d.done    = '0;
        d.ovr     = '0;
        d.ovf     = fifo_drop;
        fifo_wr   = '0;
        pick      = 1'b0;
        nx        = '0;

        // Result return: store, then step, finish or stop the owning group.
        if (q.st == SEQ_WAIT && conv_done) begin
            fifo_wr[q.cur] = 1'b1;
            d.st = SEQ_IDLE;
            nx = scan_up(q.smask[q.cur], int'(q.pos[q.cur]) + 1);
            if (!grp_en[q.cur]) begin
                d.pend[q.cur] = 1'b0;
            end else if (nx[CHW]) begin
                d.pos[q.cur] = nx[CHW-1:0];
            end else begin
                d.done[q.cur] = 1'b1;
                if (grp_cont[q.cur]) d.pos[q.cur] = first_idx(q.smask[q.cur]);
                else                 d.pend[q.cur] = 1'b0;
            end
        end

        // Enable drop and start acceptance per group.
        for (int g = 0; g < NGRP; g++) begin
            if (!grp_en[g] && !(q.st == SEQ_WAIT && int'(q.cur) == g)) begin
                d.pend[g] = 1'b0;
            end
            if (trig_req[g] && grp_en[g]) begin
                if (q.pend[g]) begin
                    d.ovr[g] = 1'b1;
                end else if (|grp_mask[g*NCH +: NCH]) begin
                    d.pend[g]  = 1'b1;
                    d.smask[g] = grp_mask[g*NCH +: NCH];
                    d.pos[g]   = first_idx(grp_mask[g*NCH +: NCH]);
                end
            end
        end

        // Fixed-priority grant, one conversion at a time.
        if (q.st == SEQ_IDLE) begin
            for (int g = 0; g < NGRP; g++) begin
                if (!pick && q.pend[g] && grp_en[g]) begin
                    pick    = 1'b1;
                    d.st    = SEQ_WAIT;
                    d.cur   = GW'(g);
                    d.start = 1'b1;
                    d.ch    = q.pos[g];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_buf
        adcseq_fifo #(.DEPTH(DEPTH), .W(WORDW)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (fifo_wr[g]),
            .wdata (wword),
            .rd    (rd_pop[g]),
            .rdata (rd_word[g*WORDW +: WORDW]),
            .empty (rd_empty[g]),
            .drop  (fifo_drop[g])
        );
    end

    assign conv_start   = q.start;
    assign conv_ch      = q.ch;
    assign grp_done     = q.done;
    assign trig_overrun = q.ovr;
    assign buf_overflow = q.ovf;

    assert_ch_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (int'(conv_ch) < NCH));

    assert_single_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_done_after_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|grp_done) |-> $past(conv_done));

    assert_done_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_done));

endmodule

// File: tb/tb_adcseq_top.sv
module tb_adcseq_top;

    localparam int NCH = 12, NG = 3, WW = 16, LAT = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NG-1:0]     grp_en = '0, grp_cont = '0, sw_start = '0, rd_pop = '0;
    logic [NG*NCH-1:0] grp_mask = '0;
    logic [1:0]        ext_trig = '0;
    logic              conv_start, conv_done;
    logic [3:0]        conv_ch;
    logic [9:0]        conv_data;
    logic [NG*WW-1:0]  rd_word;
    logic [NG-1:0]     rd_empty, grp_done, trig_overrun, buf_overflow;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int log_ch [0:255];
    int log_n = 0;
    int done_cnt [NG], ovr_cnt [NG], ovf_cnt [NG];
    int wide_cnt = 0;
    logic [NG-1:0] prev_done = '0;
    int dr_w [0:31];
    int dr_n;

    always #5 clk = ~clk;

    adcseq_top dut (
        .clk(clk), .rst_n(rst_n), .grp_en(grp_en), .grp_cont(grp_cont),
        .grp_mask(grp_mask), .sw_start(sw_start), .ext_trig(ext_trig),
        .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
        .conv_data(conv_data), .rd_pop(rd_pop), .rd_word(rd_word),
        .rd_empty(rd_empty), .grp_done(grp_done), .trig_overrun(trig_overrun),
        .buf_overflow(buf_overflow)
    );

    function automatic int fval(input int ch);
        return (ch * 73 + 5) % 1024;
    endfunction

    function automatic int expw(input int ch);
        return (ch << 10) | fval(ch);
    endfunction

    // Converter stand-in: done LAT cycles after a start.
    int   cv_cnt = 0;
    int   cv_ch = 0;
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (!rst_n) begin
            cv_cnt <= 0;
            conv_data <= '0;
        end else if (cv_cnt != 0) begin
            cv_cnt <= cv_cnt - 1;
            if (cv_cnt == 1) begin
                conv_done <= 1'b1;
                conv_data <= 10'(fval(cv_ch));
            end
        end else if (conv_start) begin
            cv_cnt <= LAT;
            cv_ch  <= int'(conv_ch);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_start && log_n < 256) begin
                log_ch[log_n] = int'(conv_ch);
                log_n++;
            end
            for (int g = 0; g < NG; g++) begin
                if (grp_done[g]) done_cnt[g]++;
                if (grp_done[g] && prev_done[g]) wide_cnt++;
                if (trig_overrun[g]) ovr_cnt[g]++;
                if (buf_overflow[g]) ovf_cnt[g]++;
            end
            prev_done = grp_done;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr();
        log_n = 0;
        for (int g = 0; g < NG; g++) begin
            done_cnt[g] = 0; ovr_cnt[g] = 0; ovf_cnt[g] = 0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic kick(input int g);
        sw_start[g] = 1'b1;
        @(negedge clk);
        sw_start[g] = 1'b0;
    endtask

    task automatic wait_done(input int g, input int k);
        for (int i = 0; i < 3000; i++) begin
            if (done_cnt[g] >= k) break;
            @(negedge clk);
        end
    endtask

    task automatic drain(input int g);
        dr_n = 0;
        for (int i = 0; i < 40; i++) begin
            if (rd_empty[g]) break;
            if (dr_n < 32) dr_w[dr_n] = int'(rd_word[g*WW +: WW]);
            dr_n++;
            rd_pop[g] = 1'b1;
            @(negedge clk);
            rd_pop[g] = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int k, m, exp_cnt;
        clr();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1, R3)
        chk(conv_start == 1'b0, "R1 reset start", int'(conv_start), 0);
        chk(rd_empty == 3'b111, "R3 reset empty", int'(rd_empty), 7);
        chk(grp_done == 3'b000, "R9 reset done", int'(grp_done), 0);

        // Mask sweep on the software-only group (R2, R8, R9)
        grp_en = 3'b100;
        for (m = 1; m < 4096; m += 3) begin
            clr();
            grp_mask[2*NCH +: NCH] = 12'(m);
            kick(2);
            wait_done(2, 1);
            idle(2);
            drain(2);
            exp_cnt = $countones(12'(m));
            chk(dr_n == exp_cnt, "R2 word count", dr_n, exp_cnt);
            chk(done_cnt[2] == 1, "R8 one pass", done_cnt[2], 1);
            k = 0;
            for (int ch = 0; ch < NCH; ch++) begin
                if (m[ch]) begin
                    chk(dr_w[k] == expw(ch), "R2 word order", dr_w[k], expw(ch));
                    k++;
                end
            end
        end

        // Priority with simultaneous starts (R4)
        clr();
        grp_en = 3'b111;
        grp_mask = {12'hC00, 12'h060, 12'h003};
        sw_start = 3'b111;
        @(negedge clk);
        sw_start = 3'b000;
        idle(60);
        begin
            int exp_seq [6] = '{0, 1, 5, 6, 10, 11};
            chk(log_n == 6, "R4 start count", log_n, 6);
            for (int i = 0; i < 6; i++)
                chk(log_ch[i] == exp_seq[i], "R4 order", log_ch[i], exp_seq[i]);
        end
        for (int g = 0; g < NG; g++) begin
            drain(g);
            chk(dr_n == 2, "R3 per-group fifo", dr_n, 2);
        end

        // Cut-in between channels, not mid-conversion (R4)
        clr();
        grp_mask = {12'h700, 12'h000, 12'h003};
        kick(2);
        for (int i = 0; i < 50 && log_n == 0; i++) @(negedge clk);
        kick(0);
        idle(60);
        begin
            int exp_seq [5] = '{8, 0, 1, 9, 10};
            chk(log_n == 5, "R4 cut-in count", log_n, 5);
            for (int i = 0; i < 5; i++)
                chk(log_ch[i] == exp_seq[i], "R4 cut-in order", log_ch[i], exp_seq[i]);
        end
        drain(0); drain(2);

        // Captured mask (R6)
        clr();
        grp_mask[0 +: NCH] = 12'h00F;
        kick(0);
        grp_mask[0 +: NCH] = 12'hF00;
        wait_done(0, 1);
        idle(2);
        drain(0);
        chk(dr_n == 4, "R6 captured mask count", dr_n, 4);
        chk(dr_w[3] == expw(3), "R6 captured mask last", dr_w[3], expw(3));

        // Disabled group and empty mask are ignored (R6)
        clr();
        grp_en = 3'b101;
        grp_mask[NCH +: NCH] = 12'h00F;
        kick(1);
        idle(30);
        chk(log_n == 0, "R6 disabled ignored", log_n, 0);
        grp_en = 3'b111;
        grp_mask[NCH +: NCH] = 12'h000;
        kick(1);
        idle(30);
        chk(log_n == 0 && done_cnt[1] == 0, "R6 zero mask ignored", log_n, 0);
        chk(rd_empty[1] == 1'b1, "R6 zero mask fifo", int'(rd_empty[1]), 1);

        // External line: one pass per rising edge, level and fall ignored (R5)
        clr();
        grp_mask[0 +: NCH] = 12'h010;
        ext_trig[0] = 1'b1;
        idle(50);
        chk(log_n == 1, "R5 held high one pass", log_n, 1);
        chk(done_cnt[0] == 1, "R5 done once", done_cnt[0], 1);
        ext_trig[0] = 1'b0;
        idle(30);
        chk(log_n == 1, "R5 falling edge ignored", log_n, 1);
        ext_trig[0] = 1'b1;
        idle(30);
        chk(log_n == 2 && log_ch[1] == 4, "R5 second edge", log_n, 2);
        ext_trig[0] = 1'b0;
        grp_mask[NCH +: NCH] = 12'h200;
        ext_trig[1] = 1'b1;
        idle(30);
        chk(log_n == 3 && log_ch[2] == 9, "R5 group 1 line", log_ch[2], 9);
        ext_trig[1] = 1'b0;
        drain(0); drain(1);

        // Start to a busy group (R7)
        clr();
        grp_mask[0 +: NCH] = 12'hFFF;
        kick(0);
        idle(5);
        kick(0);
        wait_done(0, 1);
        idle(30);
        chk(ovr_cnt[0] == 1, "R7 overrun strobe", ovr_cnt[0], 1);
        chk(done_cnt[0] == 1, "R7 busy start ignored", done_cnt[0], 1);
        drain(0);
        chk(dr_n == 12, "R7 single pass stored", dr_n, 12);

        // Continuous pass and disable stop (R8, R9, R10)
        clr();
        grp_cont = 3'b010;
        grp_mask[NCH +: NCH] = 12'h021;
        kick(1);
        wait_done(1, 3);
        grp_en[1] = 1'b0;
        idle(30);
        k = log_n;
        idle(30);
        chk(log_n == k, "R10 stopped after disable", log_n, k);
        chk(log_n >= 6, "R8 repeated passes", log_n, 6);
        for (int i = 0; i < log_n; i++)
            chk(log_ch[i] == ((i % 2 == 0) ? 0 : 5), "R8 pass restart", log_ch[i], (i % 2 == 0) ? 0 : 5);
        chk(done_cnt[1] == log_n / 2, "R9 done per pass", done_cnt[1], log_n / 2);
        chk(wide_cnt == 0, "R9 done width", wide_cnt, 0);
        drain(1);
        chk(dr_n == log_n, "R10 in-flight result stored", dr_n, log_n);
        grp_en[1] = 1'b1;
        grp_cont = 3'b000;

        // Disable discards a pending start (R10)
        clr();
        grp_mask = {12'h300, 12'h000, 12'h001};
        kick(2);
        for (int i = 0; i < 50 && log_n == 0; i++) @(negedge clk);
        kick(0);
        grp_en[0] = 1'b0;
        idle(40);
        chk(log_n == 2 && log_ch[1] == 9, "R10 pending discarded", log_n, 2);
        chk(rd_empty[0] == 1'b1, "R10 no result for discarded", int'(rd_empty[0]), 1);
        drain(2);
        grp_en[0] = 1'b1;

        // Overflow: continuous group, no reads (R3)
        clr();
        grp_cont = 3'b001;
        grp_mask[0 +: NCH] = 12'h0FF;
        kick(0);
        for (int i = 0; i < 3000 && ovf_cnt[0] == 0; i++) @(negedge clk);
        grp_en[0] = 1'b0;
        idle(30);
        chk(ovf_cnt[0] == log_n - 16, "R3 drop count", ovf_cnt[0], log_n - 16);
        drain(0);
        chk(dr_n == 16, "R3 depth kept", dr_n, 16);
        for (int i = 0; i < 16 && i < dr_n; i++)
            chk(dr_w[i] == expw(i % 8), "R3 oldest kept", dr_w[i], expw(i % 8));

        chk(wide_cnt == 0, "R9 done width final", wide_cnt, 0);
        finish_run();
    end

endmodule